// File: doc/BRIEF.md
# Paired-Result Register Writeback Stage

This block is the core-side stage that commits accelerator results to the integer register file. Each response carries the offloaded instruction word, one or two result words and a flag that asks for a paired write. The destination index is taken from bits [11:7] of the instruction word. The block drives a register file that has two write ports.

A single write places the first result in Xn. A paired write places the first result in Xn and the second result in Xn+1, and both writes happen in the same cycle. A paired write is honoured only when n is even and non-zero. Any other paired request is reduced to a single write and reported on an error output. Writes to x0 never reach the register file.

The second write path exists only when the `DUAL_EN` parameter is 1. When it is 0, that path is tied to zero and left for synthesis to remove. A small state machine holds the kind of the committed response:

| State | Meaning |
|---|---|
| `ST_IDLE` | Nothing is committed this cycle. |
| `ST_SINGLE` | One write is issued on port 0. |
| `ST_PAIR` | Writes are issued on both ports. |
| `ST_DROP` | A response was accepted but it targets x0, so nothing is written. |

Every transition is taken at each clock edge:
- An accepted response moves the machine to `ST_PAIR`, `ST_SINGLE` or `ST_DROP`, chosen by the classification of that response.
- A cycle with no accepted response returns the machine to `ST_IDLE`.

Top module: `dual_wb_port`

## Requirements
- R1: While reset is held, `wp0_en`, `wp1_en`, `wb_err` and `rsp_ready` are all 0.
- R2: The destination index n is bits [11:7] of `rsp_instr`. No other bit of the instruction word affects the writes.
- R3: An accepted response with `rsp_dual`=0 and n≠0 gives, in the next cycle, `wp0_en`=1, `wp0_addr`=n, `wp0_data`=`rsp_data0`, `wp1_en`=0 and `wb_err`=0.
- R4: An accepted response with `rsp_dual`=1, n even and n≠0 (and `DUAL_EN`=1) gives, in the next cycle, both enables at 1, `wp0_addr`=n with `rsp_data0`, `wp1_addr`=n+1 with `rsp_data1`, and `wb_err`=0.
- R5: An accepted single response with n=0 writes nothing and raises no error.
- R6: An accepted paired response with an odd n is reduced to a single write of `rsp_data0` to Xn, with `wb_err`=1 in that same cycle.
- R7: An accepted paired response with n=0 writes nothing, and `wb_err` is 1 in the following cycle.
- R8: The enables and `wb_err` are high for exactly the one cycle after each accepted response. A cycle with no acceptance is followed by a cycle with all of them at 0.
- R9: With `DUAL_EN`=0, `wp1_en` is always 0. Every paired request is handled as in R6 or R7, and so is reported on `wb_err`.
- R10: From the first clock edge after reset is released, `rsp_ready` stays at 1. Back-to-back responses are each committed in the cycle after their own acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Response is offered |
| rsp_ready | output | 1 | Stage can take a response |
| rsp_instr | input | INSTR_W | Offloaded instruction word; bits [11:7] give n |
| rsp_dual | input | 1 | Request for a paired write to Xn and Xn+1 |
| rsp_data0 | input | XLEN | First result word |
| rsp_data1 | input | XLEN | Second result word |
| wp0_en | output | 1 | Write enable, register file port 0 |
| wp0_addr | output | AW | Register index, port 0 |
| wp0_data | output | XLEN | Write data, port 0 |
| wp1_en | output | 1 | Write enable, register file port 1 |
| wp1_addr | output | AW | Register index, port 1 |
| wp1_data | output | XLEN | Write data, port 1 |
| wb_err | output | 1 | Paired request was downgraded |

## Verification
The commit of one response and the acceptance of the next one fall in the same cycle whenever responses arrive back to back. A new capture must then not disturb the writes that are already on the ports. The randomised stream keeps `rsp_valid` high in most cycles and mixes single, paired, odd and x0 targets. After every edge, the ports are compared against a model evaluated on the stimulus of the previous cycle only. A second instance built without the paired path receives the same stream, so every paired request there must show up as an error together with a single write.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

    // Kind of write committed in the current cycle
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_PAIR   = 2'd2,
        ST_DROP   = 2'd3
    } wb_state_e;

endpackage

// File: rtl/dwb_dest_decode.sv
module dwb_dest_decode
    import dwb_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int RD_LSB  = 7,
    parameter int AW      = 5,
    parameter bit DUAL_EN = 1'b1
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               dual_req,
    output logic [AW-1:0]      dest_idx,
    output wb_state_e          target,
    output logic               pair_err
);

    localparam int RD_MSB = RD_LSB + AW - 1;

    logic is_zero;
    logic is_odd;
    logic pair_ok;
    logic unused_instr_bits;

    assign dest_idx = instr[RD_MSB:RD_LSB];
    assign is_zero  = (dest_idx == '0);
    assign is_odd   = dest_idx[0];
    assign unused_instr_bits = ^{instr[INSTR_W-1:RD_MSB+1], instr[RD_LSB-1:0]};

    generate
        if (DUAL_EN) begin : g_pair
            assign pair_ok = dual_req && !is_zero && !is_odd;
        end else begin : g_no_pair
            assign pair_ok = 1'b0;
        end
    endgenerate

    assign pair_err = dual_req && !pair_ok;

    always_comb begin
        if (pair_ok) begin
            target = ST_PAIR;
        end else if (is_zero) begin
            target = ST_DROP;
        end else begin
            target = ST_SINGLE;
        end
    end

endmodule

// File: rtl/dwb_fsm.sv
module dwb_fsm
    import dwb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  wb_state_e target,
    output logic      en0,
    output logic      en1,
    output logic      busy
);

    wb_state_e state_q;
    wb_state_e state_d;

    always_comb begin
        state_d = accept ? target : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        en0  = 1'b0;
        en1  = 1'b0;
        busy = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_SINGLE: begin
                en0 = 1'b1;
            end
            ST_PAIR: begin
                en0 = 1'b1;
                en1 = 1'b1;
            end
            ST_DROP: begin
                en0 = 1'b0;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dwb_result_regs.sv
module dwb_result_regs #(
    parameter int XLEN    = 32,
    parameter int AW      = 5,
    parameter bit DUAL_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [AW-1:0]   idx_in,
    input  logic            err_in,
    input  logic [XLEN-1:0] data0_in,
    input  logic [XLEN-1:0] data1_in,
    output logic [AW-1:0]   idx_q,
    output logic            err_q,
    output logic [XLEN-1:0] data0_q,
    output logic [XLEN-1:0] data1_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            err_q   <= 1'b0;
            data0_q <= '0;
        end else if (accept) begin
            idx_q   <= idx_in;
            err_q   <= err_in;
            data0_q <= data0_in;
        end
    end

    generate
        if (DUAL_EN) begin : g_second
            logic [XLEN-1:0] d1_r;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d1_r <= '0;
                end else if (accept) begin
                    d1_r <= data1_in;
                end
            end
            assign data1_q = d1_r;
        end else begin : g_tied
            logic unused_data1;
            assign unused_data1 = ^data1_in;
            assign data1_q      = '0;
        end
    endgenerate

endmodule

// File: rtl/dual_wb_port.sv
module dual_wb_port
    import dwb_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int XLEN    = 32,
    parameter int NREGS   = 32,
    parameter bit DUAL_EN = 1'b1,
    parameter int AW      = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [INSTR_W-1:0] rsp_instr,
    input  logic               rsp_dual,
    input  logic [XLEN-1:0]    rsp_data0,
    input  logic [XLEN-1:0]    rsp_data1,
    output logic               wp0_en,
    output logic [AW-1:0]      wp0_addr,
    output logic [XLEN-1:0]    wp0_data,
    output logic               wp1_en,
    output logic [AW-1:0]      wp1_addr,
    output logic [XLEN-1:0]    wp1_data,
    output logic               wb_err
);

    localparam int RD_LSB = 7;

    logic            live_q;
    logic            accept;
    logic [AW-1:0]   dec_idx;
    wb_state_e       dec_target;
    logic            dec_err;
    logic [AW-1:0]   idx_q;
    logic            err_q;
    logic [XLEN-1:0] d0_q;
    logic [XLEN-1:0] d1_q;
    logic            fsm_en0;
    logic            fsm_en1;
    logic            fsm_busy;

    // Ready rises one edge after reset release and then stays up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    assign rsp_ready = live_q;
    assign accept    = rsp_valid && live_q;

    dwb_dest_decode #(
        .INSTR_W (INSTR_W),
        .RD_LSB  (RD_LSB),
        .AW      (AW),
        .DUAL_EN (DUAL_EN)
    ) u_dec (
        .instr    (rsp_instr),
        .dual_req (rsp_dual),
        .dest_idx (dec_idx),
        .target   (dec_target),
        .pair_err (dec_err)
    );

    dwb_result_regs #(
        .XLEN    (XLEN),
        .AW      (AW),
        .DUAL_EN (DUAL_EN)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .idx_in   (dec_idx),
        .err_in   (dec_err),
        .data0_in (rsp_data0),
        .data1_in (rsp_data1),
        .idx_q    (idx_q),
        .err_q    (err_q),
        .data0_q  (d0_q),
        .data1_q  (d1_q)
    );

    dwb_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .target (dec_target),
        .en0    (fsm_en0),
        .en1    (fsm_en1),
        .busy   (fsm_busy)
    );

    assign wp0_en   = fsm_en0;
    assign wp0_addr = idx_q;
    assign wp0_data = d0_q;
    assign wb_err   = err_q && fsm_busy;

    generate
        if (DUAL_EN) begin : g_port1
            assign wp1_en   = fsm_en1;
            assign wp1_addr = {idx_q[AW-1:1], 1'b1};
            assign wp1_data = d1_q;
        end else begin : g_port1_off
            logic unused_port1;
            assign unused_port1 = fsm_en1 ^ (^d1_q);
            assign wp1_en   = 1'b0;
            assign wp1_addr = '0;
            assign wp1_data = '0;
        end
    endgenerate

endmodule

// File: rtl/dual_wb_port_chk.sv
module dual_wb_port_chk #(
    parameter int INSTR_W = 32,
    parameter int XLEN    = 32,
    parameter int AW      = 5,
    parameter bit DUAL_EN = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [INSTR_W-1:0] rsp_instr,
    input logic               rsp_dual,
    input logic [XLEN-1:0]    rsp_data0,
    input logic               wp0_en,
    input logic [AW-1:0]      wp0_addr,
    input logic [XLEN-1:0]    wp0_data,
    input logic               wp1_en,
    input logic [AW-1:0]      wp1_addr,
    input logic               wb_err
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rst_n |-> (!wp0_en && !wp1_en && !wb_err && !rsp_ready)));

    // R3
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && !rsp_dual && rsp_instr[11:7] != '0)
        |=> (wp0_en && !wp1_en && !wb_err && wp0_data == $past(rsp_data0)
             && wp0_addr == $past(rsp_instr[11:7])));

    // R4
    pair_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp1_en |-> (wp0_en && !wp0_addr[0] && wp0_addr != '0 && wp1_addr == wp0_addr + 1'b1));

    // R5
    no_x0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp0_en |-> (wp0_addr != '0));

    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |-> !wp1_en);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_ready) |=> (!wp0_en && !wp1_en && !wb_err));

    // R9
    no_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !DUAL_EN |-> !wp1_en);

    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> rsp_ready);

endmodule

bind dual_wb_port dual_wb_port_chk #(
    .INSTR_W (INSTR_W),
    .XLEN    (XLEN),
    .AW      (AW),
    .DUAL_EN (DUAL_EN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_instr (rsp_instr),
    .rsp_dual  (rsp_dual),
    .rsp_data0 (rsp_data0),
    .wp0_en    (wp0_en),
    .wp0_addr  (wp0_addr),
    .wp0_data  (wp0_data),
    .wp1_en    (wp1_en),
    .wp1_addr  (wp1_addr),
    .wb_err    (wb_err)
);

// File: tb/sim_dual_wb_port.sv
module sim_dual_wb_port;

    localparam int XLEN = 32;
    localparam int AW   = 5;

    typedef struct packed {
        logic            e0;
        logic [AW-1:0]   a0;
        logic [XLEN-1:0] d0;
        logic            e1;
        logic [AW-1:0]   a1;
        logic [XLEN-1:0] d1;
        logic            err;
    } exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n;
    logic            valid;
    logic [31:0]     instr;
    logic            dual;
    logic [XLEN-1:0] dat0, dat1;

    logic            a_rdy, a_e0, a_e1, a_err;
    logic [AW-1:0]   a_a0, a_a1;
    logic [XLEN-1:0] a_d0, a_d1;
    logic            b_rdy, b_e0, b_e1, b_err;
    logic [AW-1:0]   b_a0, b_a1;
    logic [XLEN-1:0] b_d0, b_d1;

    int checks = 0;
    int fails  = 0;

    dual_wb_port #(.DUAL_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .rsp_valid(valid), .rsp_ready(a_rdy),
        .rsp_instr(instr), .rsp_dual(dual), .rsp_data0(dat0), .rsp_data1(dat1),
        .wp0_en(a_e0), .wp0_addr(a_a0), .wp0_data(a_d0),
        .wp1_en(a_e1), .wp1_addr(a_a1), .wp1_data(a_d1), .wb_err(a_err)
    );

    dual_wb_port #(.DUAL_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .rsp_valid(valid), .rsp_ready(b_rdy),
        .rsp_instr(instr), .rsp_dual(dual), .rsp_data0(dat0), .rsp_data1(dat1),
        .wp0_en(b_e0), .wp0_addr(b_a0), .wp0_data(b_d0),
        .wp1_en(b_e1), .wp1_addr(b_a1), .wp1_data(b_d1), .wb_err(b_err)
    );

    function automatic exp_t model(logic v, logic [31:0] ins, logic dl,
                                   logic [XLEN-1:0] x0, logic [XLEN-1:0] x1, bit den);
        exp_t e;
        logic [AW-1:0] n;
        logic ok;
        e  = '0;
        n  = ins[11:7];
        ok = dl && den && n != '0 && !n[0];
        if (v) begin
            e.err = dl && !ok;
            e.e0  = (n != '0);
            e.a0  = n;
            e.d0  = x0;
            if (ok) begin
                e.e1 = 1'b1;
                e.a1 = n + 1'b1;
                e.d1 = x1;
            end
        end
        return e;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cmp(string req, exp_t e, logic rdy, logic e0, logic [AW-1:0] a0,
                       logic [XLEN-1:0] d0, logic e1, logic [AW-1:0] a1,
                       logic [XLEN-1:0] d1, logic err);
        chk("R10", {req, " ready"}, 64'(rdy), 64'd1);
        chk(req, "wp0_en", 64'(e0), 64'(e.e0));
        chk(req, "wp1_en", 64'(e1), 64'(e.e1));
        chk(req, "wb_err", 64'(err), 64'(e.err));
        if (e.e0) begin
            chk(req, "wp0_addr", 64'(a0), 64'(e.a0));
            chk(req, "wp0_data", 64'(d0), 64'(e.d0));
        end
        if (e.e1) begin
            chk(req, "wp1_addr", 64'(a1), 64'(e.a1));
            chk(req, "wp1_data", 64'(d1), 64'(e.d1));
        end
    endtask

    function automatic logic [31:0] mk(logic [4:0] rd);
        logic [31:0] w;
        w = $urandom;
        w[11:7] = rd;
        return w;
    endfunction

    // Drive at a falling edge, judge after the next rising edge
    task automatic step(string req, logic v, logic [31:0] ins, logic dl);
        exp_t ea, eb;
        valid = v;
        instr = ins;
        dual  = dl;
        dat0  = $urandom;
        dat1  = $urandom;
        ea = model(v, ins, dl, dat0, dat1, 1'b1);
        eb = model(v, ins, dl, dat0, dat1, 1'b0);
        @(negedge clk);
        cmp(req, ea, a_rdy, a_e0, a_a0, a_d0, a_e1, a_a1, a_d1, a_err);
        cmp("R9", eb, b_rdy, b_e0, b_a0, b_d0, b_e1, b_a1, b_d1, b_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        valid = 1'b0;
        instr = '0;
        dual  = 1'b0;
        dat0  = '0;
        dat1  = '0;
        repeat (3) @(negedge clk);
        valid = 1'b1;
        instr = mk(5'd4);
        @(negedge clk);
        // R1: nothing leaves while reset is held, even with a response offered
        chk("R1", "wp0_en", 64'(a_e0), 64'd0);
        chk("R1", "wp1_en", 64'(a_e1), 64'd0);
        chk("R1", "wb_err", 64'(a_err), 64'd0);
        chk("R1", "ready", 64'(a_rdy), 64'd0);
        valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "ready after reset", 64'(a_rdy), 64'd1);
        chk("R1", "wp0_en after reset", 64'(a_e0), 64'd0);

        step("R3", 1'b1, mk(5'd9), 1'b0);
        step("R5", 1'b1, mk(5'd0), 1'b0);
        step("R4", 1'b1, mk(5'd6), 1'b1);
        step("R4", 1'b1, mk(5'd30), 1'b1);
        step("R6", 1'b1, mk(5'd7), 1'b1);
        step("R6", 1'b1, mk(5'd31), 1'b1);
        step("R7", 1'b1, mk(5'd0), 1'b1);
        step("R8", 1'b0, mk(5'd4), 1'b1);
        step("R8", 1'b0, mk(5'd0), 1'b0);
        step("R2", 1'b1, 32'hFFFF_F8FF | (32'd17 << 7) & 32'hFFFF_F8FF | 32'h0000_0880, 1'b0);
        step("R2", 1'b1, {20'hFFFFF, 5'd12, 7'h7F}, 1'b1);
        step("R2", 1'b1, {20'h00000, 5'd12, 7'h00}, 1'b1);
        step("R4", 1'b1, mk(5'd2), 1'b1);
        step("R8", 1'b0, mk(5'd2), 1'b1);

        for (int i = 0; i < 3000; i++) begin
            step("R10", ($urandom % 4) != 0, mk(5'($urandom)), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule